// File: doc/BRIEF.md
# PWM Generator Fault Conditioning Unit

This block sits in front of one PWM generator. It takes four asynchronous fault pins and turns them into one fault-active signal. The output stage uses that signal to drive its pins to a safe level. Each pin is first synchronized. It then passes through a polarity stage, so either level can mean "fault". A source mask picks which of the conditioned pins are ORed into the generator fault. When the extended source mode is off, only pin 0 counts.

Two optional behaviours can be switched on. The first is a minimum-duration timer. It keeps the fault active for a programmed number of clock cycles after the combined raw fault clears. The second is a per-pin latch. It keeps a trigger flag set until software clears it by writing a one. A small register port gives access to the configuration, the trigger flags and a fault interrupt. The interrupt has a raw view and an enabled view, and writing a one clears it.

Top module: `pwm_fault_cond`

## Requirements
- R1: After reset, register reads return: MODE (addr 0) = 0, SENSE (addr 1) = 0, SELECT (addr 2) = 0x0001, MINPER (addr 3) = 0, TSTAT (addr 4) = 0, IRAW (addr 5) = 0 and IMASK (addr 6) = 0. The outputs `faultActive` and `faultIrq` are both 0.
- R2: Each fault pin passes through two flip-flops. A pin change made between clock edges shows on `faultActive` after the second rising edge, and not after the first.
- R3: SENSE bit i set to 1 makes pin i asserted when it is low. SENSE bit i at 0 makes pin i asserted when it is high.
- R4: With MODE bit 0 (extended source) set, the raw fault is the OR of the sense-adjusted pins whose SELECT bits are 1. Unselected pins have no effect.
- R5: With MODE bit 0 clear, only sense-adjusted pin 0 drives the raw fault, whatever SELECT holds.
- R6: With MODE bit 1 (minimum period) set and MINPER = N, `faultActive` stays high for N clock cycles after the synchronized raw fault drops. It goes low on the cycle after that.
- R7: MINPER has no effect when MODE bit 1 is clear. A MINPER value of 0 gives no stretching.
- R8: With MODE bit 2 (latch) clear, TSTAT bit i reads the live sense-adjusted state of pin i.
- R9: With MODE bit 2 set, a TSTAT bit stays set after its pin deasserts. Writing 1 to the bit clears it, and writing 0 leaves it unchanged.
- R10: If a TSTAT clear is written while the pin is still asserted, the bit stays set.
- R11: IRAW bit 0 is set by the raw fault. IMASK bit 0 and `faultIrq` equal IRAW AND MODE bit 3. Writing 1 to IRAW bit 0 clears it when no fault is present, and writing 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| faultIn | input | 4 | Asynchronous fault pins |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Combinational register read data |
| faultActive | output | 1 | Fault signal to the PWM output stage |
| faultIrq | output | 1 | Enabled fault interrupt |

## Verification
The bench builds the block with its default two-stage synchronizer and 16-bit minimum-period register. This makes the two-edge pin latency an exact cycle to sample. The bench programs a minimum period of 3, so every cycle of the stretch window can be counted, up to the cycle where the fault drops. The small map lets the bench read back every configuration and status register after each stimulus. This covers the latch set-versus-clear race and the case where a pin is ignored in legacy mode.

// File: rtl/flt_pkg.sv
package flt_pkg;
  localparam int FLT_N    = 4;
  localparam int MINPER_W = 16;
  localparam int REG_AW   = 3;
  localparam int REG_DW   = 16;

  localparam logic [REG_AW-1:0] A_MODE   = 3'd0;
  localparam logic [REG_AW-1:0] A_SENSE  = 3'd1;
  localparam logic [REG_AW-1:0] A_SEL    = 3'd2;
  localparam logic [REG_AW-1:0] A_MINPER = 3'd3;
  localparam logic [REG_AW-1:0] A_TSTAT  = 3'd4;
  localparam logic [REG_AW-1:0] A_IRAW   = 3'd5;
  localparam logic [REG_AW-1:0] A_IMASK  = 3'd6;

  typedef struct packed {
    logic                extSrc;
    logic                minPerEn;
    logic                latchEn;
    logic                intEn;
    logic [FLT_N-1:0]    sense;
    logic [FLT_N-1:0]    srcSel;
    logic [MINPER_W-1:0] minPer;
  } fltCfg_t;

  typedef struct packed {
    logic [FLT_N-1:0] statClr;
    logic             intClr;
  } fltStrb_t;
endpackage

// File: rtl/flt_ctrl.sv
module flt_ctrl
  import flt_pkg::*;
#(
  parameter logic [FLT_N-1:0] SEL_RESET = FLT_N'(1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [REG_DW-1:0] wrData,
  input  logic [REG_AW-1:0] rdAddr,
  output logic [REG_DW-1:0] rdData,
  input  logic [FLT_N-1:0]  trigStat,
  input  logic              rawInt,
  output fltCfg_t           cfg,
  output fltStrb_t          strb
);
  localparam int MODE_W = 4;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg.extSrc   <= 1'b0;
      cfg.minPerEn <= 1'b0;
      cfg.latchEn  <= 1'b0;
      cfg.intEn    <= 1'b0;
      cfg.sense    <= '0;
      cfg.srcSel   <= SEL_RESET;
      cfg.minPer   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        A_MODE: begin
          cfg.extSrc   <= wrData[0];
          cfg.minPerEn <= wrData[1];
          cfg.latchEn  <= wrData[2];
          cfg.intEn    <= wrData[3];
        end
        A_SENSE:  cfg.sense  <= wrData[FLT_N-1:0];
        A_SEL:    cfg.srcSel <= wrData[FLT_N-1:0];
        A_MINPER: cfg.minPer <= wrData[MINPER_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strb.statClr = '0;
    strb.intClr  = 1'b0;
    if (wrEn && wrAddr == A_TSTAT) strb.statClr = wrData[FLT_N-1:0];
    if (wrEn && wrAddr == A_IRAW)  strb.intClr  = wrData[0];
  end

  always_comb begin
    case (rdAddr)
      A_MODE:   rdData = REG_DW'({cfg.intEn, cfg.latchEn, cfg.minPerEn, cfg.extSrc});
      A_SENSE:  rdData = REG_DW'(cfg.sense);
      A_SEL:    rdData = REG_DW'(cfg.srcSel);
      A_MINPER: rdData = REG_DW'(cfg.minPer);
      A_TSTAT:  rdData = REG_DW'(trigStat);
      A_IRAW:   rdData = REG_DW'(rawInt);
      A_IMASK:  rdData = REG_DW'(rawInt & cfg.intEn);
      default:  rdData = '0;
    endcase
  end

  // R1
  mode_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddr == A_MODE) |-> (rdData[REG_DW-1:MODE_W] == '0));
endmodule

// File: rtl/flt_dpath.sv
module flt_dpath
  import flt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [FLT_N-1:0] faultIn,
  input  fltCfg_t          cfg,
  input  fltStrb_t         strb,
  output logic             faultActive,
  output logic             faultIrq,
  output logic [FLT_N-1:0] trigStat,
  output logic             rawInt
);
  logic [FLT_N-1:0]    synced;
  logic [FLT_N-1:0]    adj;
  logic [FLT_N-1:0]    effMask;
  logic [FLT_N-1:0]    latchQ;
  logic [MINPER_W-1:0] cnt;
  logic                combRaw;
  logic                stretchOn;

  for (genvar i = 0; i < FLT_N; i++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ <= '0;
      else       syncQ <= {syncQ[SYNC_STAGES-2:0], faultIn[i]};
    end
    assign synced[i] = syncQ[SYNC_STAGES-1];
  end

  assign adj     = synced ^ cfg.sense;
  assign effMask = cfg.extSrc ? cfg.srcSel : FLT_N'(1);
  assign combRaw = |(adj & effMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cnt <= '0;
    else if (combRaw)      cnt <= cfg.minPer;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign stretchOn   = cfg.minPerEn && (cnt != '0);
  assign faultActive = combRaw | stretchOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             latchQ <= '0;
    else if (!cfg.latchEn) latchQ <= '0;
    else                   latchQ <= (latchQ & ~strb.statClr) | adj;
  end

  assign trigStat = cfg.latchEn ? (latchQ | adj) : adj;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rawInt <= 1'b0;
    else       rawInt <= (rawInt & ~strb.intClr) | combRaw;
  end

  assign faultIrq = rawInt & cfg.intEn;

  // R6
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(combRaw) && cfg.minPerEn && $past(cfg.minPer) != '0) |-> faultActive);
  // R11
  int_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    combRaw |=> rawInt);
  // R11
  int_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.intClr && !combRaw) |=> !rawInt);

  for (genvar j = 0; j < FLT_N; j++) begin : g_chk
    // R9
    latch_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfg.latchEn && latchQ[j] && !strb.statClr[j]) |=> (!cfg.latchEn || trigStat[j]));
    // R10
    latch_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfg.latchEn && adj[j]) |=> (!cfg.latchEn || trigStat[j]));
  end
endmodule

// File: rtl/pwm_fault_cond.sv
module pwm_fault_cond
  import flt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [FLT_N-1:0]       faultIn,
  input  logic                   wrEn,
  input  logic [REG_AW-1:0]      wrAddr,
  input  logic [REG_DW-1:0]      wrData,
  input  logic [REG_AW-1:0]      rdAddr,
  output logic [REG_DW-1:0]      rdData,
  output logic                   faultActive,
  output logic                   faultIrq
);
  fltCfg_t          cfg;
  fltStrb_t         strb;
  logic [FLT_N-1:0] trigStat;
  logic             rawInt;

  flt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .trigStat(trigStat), .rawInt(rawInt),
    .cfg(cfg), .strb(strb)
  );

  flt_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .faultIn(faultIn), .cfg(cfg), .strb(strb),
    .faultActive(faultActive), .faultIrq(faultIrq), .trigStat(trigStat),
    .rawInt(rawInt)
  );
endmodule

// File: tb/pwm_fault_cond_tb.sv
module pwm_fault_cond_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  fIn = '0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        faultActive;
  logic        faultIrq;

  int total = 0;
  int bad = 0;
  bit doneFlag = 0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       req;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  pwm_fault_cond u_dut (
    .clk(clk), .rstN(rstN), .faultIn(fIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .faultActive(faultActive), .faultIrq(faultIrq)
  );

  // monitor: pops expectations and compares with the design's outputs
  initial begin
    forever begin
      wait (q.size() != 0);
      #1;
      begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          0:       act = rdData;
          1:       act = {15'b0, faultActive};
          default: act = {15'b0, faultIrq};
        endcase
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [2:0] addr,
                      input logic [15:0] exp, input string req);
    item_t it;
    rdAddr = addr;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chkReg(input logic [2:0] a, input logic [15:0] e, input string r);
    push(0, a, e, r);
  endtask
  task automatic chkAct(input logic e, input string r);
    push(1, 3'd0, {15'b0, e}, r);
  endtask
  task automatic chkIrq(input logic e, input string r);
    push(2, 3'd0, {15'b0, e}, r);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    #1;
    wrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!doneFlag) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    // R1 reset state
    chkReg(3'd0, 16'h0000, "R1 mode");
    chkReg(3'd1, 16'h0000, "R1 sense");
    chkReg(3'd2, 16'h0001, "R1 select");
    chkReg(3'd3, 16'h0000, "R1 minper");
    chkReg(3'd4, 16'h0000, "R1 tstat");
    step(1);
    chkReg(3'd5, 16'h0000, "R1 iraw");
    chkReg(3'd6, 16'h0000, "R1 imask");
    chkAct(1'b0, "R1 faultActive");
    chkIrq(1'b0, "R1 faultIrq");

    // R2 two-edge latency, legacy mode on pin 0
    fIn = 4'b0001;
    step(1); chkAct(1'b0, "R2 after one edge");
    step(1); chkAct(1'b1, "R2 after two edges");
    // R5 legacy ignores other pins and SELECT
    fIn = 4'b0010;
    step(2); chkAct(1'b0, "R5 pin1 ignored");
    wr(3'd2, 16'h0002);
    chkAct(1'b0, "R5 select ignored");
    fIn = 4'b0001;
    step(2); chkAct(1'b1, "R5 pin0 still used");

    // R4 extended source OR
    wr(3'd0, 16'h0001);
    wr(3'd2, 16'h0006);
    fIn = 4'b0100;
    step(2); chkAct(1'b1, "R4 pin2 selected");
    fIn = 4'b1001;
    step(2); chkAct(1'b0, "R4 unselected pins");
    fIn = 4'b0010;
    step(2); chkAct(1'b1, "R4 pin1 selected");

    // R3 polarity
    fIn = 4'b0000;
    wr(3'd1, 16'h0004);
    step(2); chkAct(1'b1, "R3 pin2 active low asserted");
    fIn = 4'b0100;
    step(2); chkAct(1'b0, "R3 pin2 active low released");
    wr(3'd1, 16'h0000);

    // R8 live status
    fIn = 4'b1010;
    step(2); chkReg(3'd4, 16'h000A, "R8 live set");
    fIn = 4'b0000;
    step(2); chkReg(3'd4, 16'h0000, "R8 live clear");

    // R9 latched status
    wr(3'd0, 16'h0005);
    fIn = 4'b0011;
    step(2); chkReg(3'd4, 16'h0003, "R9 asserted");
    fIn = 4'b0000;
    step(2); chkReg(3'd4, 16'h0003, "R9 held");
    wr(3'd4, 16'h0000);
    chkReg(3'd4, 16'h0003, "R9 write zero no effect");
    wr(3'd4, 16'h0001);
    chkReg(3'd4, 16'h0002, "R9 clear bit0");
    wr(3'd4, 16'h0002);
    chkReg(3'd4, 16'h0000, "R9 clear bit1");

    // R10 set wins over clear
    fIn = 4'b0100;
    step(2);
    wr(3'd4, 16'h0004);
    chkReg(3'd4, 16'h0004, "R10 clear while asserted");
    fIn = 4'b0000;
    step(2); chkReg(3'd4, 16'h0004, "R10 still latched");
    wr(3'd4, 16'h0004);
    chkReg(3'd4, 16'h0000, "R10 clear after release");

    // R6 stretch by 3 cycles
    wr(3'd0, 16'h0003);
    wr(3'd2, 16'h0001);
    wr(3'd3, 16'h0003);
    fIn = 4'b0001;
    step(2); chkAct(1'b1, "R6 asserted");
    fIn = 4'b0000;
    step(4); chkAct(1'b1, "R6 last stretched cycle");
    step(1); chkAct(1'b0, "R6 stretch ends");

    // R7 zero period and disabled mode
    wr(3'd3, 16'h0000);
    fIn = 4'b0001;
    step(2);
    fIn = 4'b0000;
    step(2); chkAct(1'b0, "R7 minper zero");
    wr(3'd3, 16'h0003);
    wr(3'd0, 16'h0001);
    fIn = 4'b0001;
    step(2);
    fIn = 4'b0000;
    step(2); chkAct(1'b0, "R7 mode disabled");
    chkReg(3'd3, 16'h0003, "R7 minper readback");

    // R11 interrupt
    wr(3'd5, 16'h0001);
    chkReg(3'd5, 16'h0000, "R11 raw cleared");
    fIn = 4'b0001;
    step(3);
    chkReg(3'd5, 16'h0001, "R11 raw set");
    chkReg(3'd6, 16'h0000, "R11 masked off");
    chkIrq(1'b0, "R11 irq disabled");
    wr(3'd0, 16'h0009);
    chkReg(3'd6, 16'h0001, "R11 masked on");
    chkIrq(1'b1, "R11 irq enabled");
    fIn = 4'b0000;
    step(3);
    wr(3'd5, 16'h0000);
    chkReg(3'd5, 16'h0001, "R11 write zero no effect");
    wr(3'd5, 16'h0001);
    chkReg(3'd5, 16'h0000, "R11 write one clears");
    chkIrq(1'b0, "R11 irq after clear");

    doneFlag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule